// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a byte-wide parallel flash device and interprets its bus cycles. Each write strobe delivers one address/data pair, sampled on a clock edge. The block matches these pairs against fixed multi-cycle unlock sequences. A sequence that completes becomes one request to the array engine: reset to read mode, byte program, whole-array erase or sector erase. Every request carries an operation code, an address and a data byte, and is held until the engine acknowledges it.

One sequence does not produce a request. It switches the read path into identifier mode. In that mode, reads at the two lowest addresses return a manufacturer byte and a device byte in place of array data. A parameter selects the device byte for the top-boot or bottom-boot variant.

Any write that does not fit the expected step abandons the sequence and returns the decoder to read-array mode. While the engine reports busy, the decoder accepts only the reset command.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A command byte is honoured only after the two key writes: data AAh to address 5555h, then data 55h to address 2AAAh. The command byte on its own does nothing.
- R2: The key and command address compares look only at wrAddr[14:0]. The upper address bits may take any value.
- R3: A write of F0h to any address returns the decoder to read mode and issues reqOp 0 (reset), carrying that write's address and data. This applies in every step except the program-data step, and in that step too while engineBusy is high. The keyed three-write form (keys, then F0h to 5555h) gives the same result.
- R4: After the keys, a write of 90h to 5555h sets idMode to 1 and issues no request. While idMode is 1, rdData is 01h when rdAddr is 0, the device byte when rdAddr is 1, and 00h at any other address. While idMode is 0, rdData equals arrayRdData.
- R5: The device byte is 40h when TOP_BOOT is 1 and A1h when TOP_BOOT is 0.
- R6: After the keys, a write of A0h to 5555h arms programming. The next write issues reqOp 1 (program) with that write's full address and data, even when the data is F0h.
- R7: The erase sequence is: keys, 80h to 5555h, keys again, then 10h to 5555h. Its last write issues reqOp 2 (chip erase).
- R8: The same five-write erase prefix followed by 30h to any address issues reqOp 3 (sector erase), with reqAddr set to that address.
- R9: A write that does not match its step issues no request, clears idMode and restarts matching from the first key.
- R10: reqValid rises in the cycle after the edge that samples the final write. reqOp, reqAddr and reqData then stay stable until an edge that samples reqAck high, and reqValid falls after that edge. Writes sampled while reqValid is high are ignored and change neither the sequence nor idMode.
- R11: While engineBusy is high, a write other than F0h aborts the sequence as in R9, so no program or erase request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrStrobe | input | 1 | Write cycle valid in this clock |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | ADDR_W | Read address |
| arrayRdData | input | 8 | Read data from the array |
| rdData | output | 8 | Read data to the bus |
| idMode | output | 1 | Identifier mode active |
| engineBusy | input | 1 | Array engine busy with program or erase |
| reqValid | output | 1 | Request pending |
| reqOp | output | 2 | 0 reset, 1 program, 2 chip erase, 3 sector erase |
| reqAddr | output | ADDR_W | Request address |
| reqData | output | 8 | Request data |
| reqAck | input | 1 | Engine takes the request |

## Verification
The bench writes F0h as program data. A decoder that takes the one-write reset too eagerly would issue a reset there and lose the program. It sends key writes with the upper address bits set, which catches a design that compares the full address: such a design would refuse every command. It also issues writes while a request is pending and while the engine is busy. A design without those guards would overwrite a pending payload, change idMode, or start an erase behind a busy engine. Each write is checked against a behavioural model that reclassifies the stored history of writes, and deliberately wrong key addresses confirm that a mismatch clears idMode and restarts the sequence.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int DATA_W = 8;
  localparam int CMP_W  = 15;

  localparam logic [CMP_W-1:0]  KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0]  KEY_ADDR_B = 15'h2AAA;
  localparam logic [DATA_W-1:0] KEY_DATA_A = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_DATA_B = 8'h55;
  localparam logic [DATA_W-1:0] CMD_RESET  = 8'hF0;
  localparam logic [DATA_W-1:0] CMD_IDENT  = 8'h90;
  localparam logic [DATA_W-1:0] CMD_PROG   = 8'hA0;
  localparam logic [DATA_W-1:0] CMD_ERASE  = 8'h80;
  localparam logic [DATA_W-1:0] CMD_CHIP   = 8'h10;
  localparam logic [DATA_W-1:0] CMD_SECTOR = 8'h30;

  localparam logic [DATA_W-1:0] MFR_ID     = 8'h01;
  localparam logic [DATA_W-1:0] DEV_ID_TOP = 8'h40;
  localparam logic [DATA_W-1:0] DEV_ID_BOT = 8'hA1;

  typedef enum logic [1:0] {
    OP_RESET        = 2'd0,
    OP_PROGRAM      = 2'd1,
    OP_CHIP_ERASE   = 2'd2,
    OP_SECTOR_ERASE = 2'd3
  } reqOp_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ER1, ST_ER2, ST_ER3
  } seqStep_e;

  // Decoded view of the current write, produced by the datapath
  typedef struct packed {
    logic addrA;
    logic addrB;
    logic dKeyA;
    logic dKeyB;
    logic dReset;
    logic dIdent;
    logic dProg;
    logic dErase;
    logic dChip;
    logic dSector;
  } wrMatch_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   loadReq;
    reqOp_e op;
    logic   setId;
    logic   clrId;
  } ctrlStrobe_t;

endpackage

// File: rtl/fcd_seq_ctrl.sv
module fcd_seq_ctrl
  import fcd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStrobe,
  input  logic        engineBusy,
  input  logic        reqPending,
  input  wrMatch_t    match,
  output ctrlStrobe_t strobe,
  output logic        progArmed
);

  seqStep_e step, nextStep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) step <= ST_IDLE;
    else       step <= nextStep;
  end

  assign progArmed = (step == ST_PROG);

  always_comb begin
    nextStep       = step;
    strobe.loadReq = 1'b0;
    strobe.op      = OP_RESET;
    strobe.setId   = 1'b0;
    strobe.clrId   = 1'b0;
    if (wrStrobe && !reqPending) begin
      if (match.dReset && (step != ST_PROG || engineBusy)) begin
        strobe.loadReq = 1'b1;
        strobe.op      = OP_RESET;
        strobe.clrId   = 1'b1;
        nextStep       = ST_IDLE;
      end else if (engineBusy) begin
        strobe.clrId = 1'b1;
        nextStep     = ST_IDLE;
      end else begin
        // default: abort the sequence
        strobe.clrId = 1'b1;
        nextStep     = ST_IDLE;
        unique case (step)
          ST_IDLE: if (match.addrA && match.dKeyA) begin
            nextStep = ST_KEY1; strobe.clrId = 1'b0;
          end
          ST_KEY1: if (match.addrB && match.dKeyB) begin
            nextStep = ST_KEY2; strobe.clrId = 1'b0;
          end
          ST_KEY2: if (match.addrA && match.dIdent) begin
            strobe.setId = 1'b1; strobe.clrId = 1'b0;
          end else if (match.addrA && match.dProg) begin
            nextStep = ST_PROG; strobe.clrId = 1'b0;
          end else if (match.addrA && match.dErase) begin
            nextStep = ST_ER1; strobe.clrId = 1'b0;
          end
          ST_PROG: begin
            strobe.loadReq = 1'b1;
            strobe.op      = OP_PROGRAM;
          end
          ST_ER1: if (match.addrA && match.dKeyA) begin
            nextStep = ST_ER2; strobe.clrId = 1'b0;
          end
          ST_ER2: if (match.addrB && match.dKeyB) begin
            nextStep = ST_ER3; strobe.clrId = 1'b0;
          end
          ST_ER3: if (match.addrA && match.dChip) begin
            strobe.loadReq = 1'b1; strobe.op = OP_CHIP_ERASE;
          end else if (match.dSector) begin
            strobe.loadReq = 1'b1; strobe.op = OP_SECTOR_ERASE;
          end
          default: nextStep = ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayRdData,
  input  ctrlStrobe_t       strobe,
  input  logic              reqAck,
  output wrMatch_t          match,
  output logic              reqValid,
  output reqOp_e            reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              idMode,
  output logic [DATA_W-1:0] rdData
);

  logic [CMP_W-1:0]  cmpAddr;
  logic [DATA_W-1:0] devId;

  assign cmpAddr = wrAddr[CMP_W-1:0];

  always_comb begin
    match.addrA   = (cmpAddr == KEY_ADDR_A);
    match.addrB   = (cmpAddr == KEY_ADDR_B);
    match.dKeyA   = (wrData == KEY_DATA_A);
    match.dKeyB   = (wrData == KEY_DATA_B);
    match.dReset  = (wrData == CMD_RESET);
    match.dIdent  = (wrData == CMD_IDENT);
    match.dProg   = (wrData == CMD_PROG);
    match.dErase  = (wrData == CMD_ERASE);
    match.dChip   = (wrData == CMD_CHIP);
    match.dSector = (wrData == CMD_SECTOR);
  end

  generate
    if (TOP_BOOT) begin : g_topId
      assign devId = DEV_ID_TOP;
    end else begin : g_botId
      assign devId = DEV_ID_BOT;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      reqOp    <= OP_RESET;
      reqAddr  <= '0;
      reqData  <= '0;
    end else if (strobe.loadReq) begin
      reqValid <= 1'b1;
      reqOp    <= strobe.op;
      reqAddr  <= wrAddr;
      reqData  <= wrData;
    end else if (reqAck) begin
      reqValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             idMode <= 1'b0;
    else if (strobe.clrId) idMode <= 1'b0;
    else if (strobe.setId) idMode <= 1'b1;
  end

  always_comb begin
    if (!idMode)                                rdData = arrayRdData;
    else if (rdAddr == ADDR_W'(0))              rdData = MFR_ID;
    else if (rdAddr == ADDR_W'(1))              rdData = devId;
    else                                        rdData = '0;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        arrayRdData,
  output logic [7:0]        rdData,
  output logic              idMode,
  input  logic              engineBusy,
  output logic              reqValid,
  output logic [1:0]        reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData,
  input  logic              reqAck
);

  wrMatch_t    match;
  ctrlStrobe_t strobe;
  reqOp_e      reqOpInt;
  logic        progArmed;

  fcd_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrStrobe   (wrStrobe),
    .engineBusy (engineBusy),
    .reqPending (reqValid),
    .match      (match),
    .strobe     (strobe),
    .progArmed  (progArmed)
  );

  fcd_datapath #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .arrayRdData (arrayRdData),
    .strobe      (strobe),
    .reqAck      (reqAck),
    .match       (match),
    .reqValid    (reqValid),
    .reqOp       (reqOpInt),
    .reqAddr     (reqAddr),
    .reqData     (reqData),
    .idMode      (idMode),
    .rdData      (rdData)
  );

  assign reqOp = reqOpInt;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStrobe,
  input logic [7:0]        wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              engineBusy,
  input logic              reqAck,
  input logic              reqValid,
  input logic [1:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [7:0]        reqData,
  input logic              idMode,
  input logic [7:0]        rdData,
  input logic              progArmed
);

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck |=> reqValid && $stable(reqOp) && $stable(reqAddr) && $stable(reqData));

  assert_req_drops_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqAck |=> !reqValid);

  assert_no_spurious_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid && !wrStrobe |=> !reqValid);

  assert_pending_ignores_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && reqValid |=> $stable(idMode));

  assert_busy_only_reset_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && engineBusy && !reqValid |=> !reqValid || reqOp == 2'(OP_RESET));

  assert_reset_escape_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && !reqValid && wrData == CMD_RESET && (!progArmed || engineBusy)
      |=> reqValid && reqOp == 2'(OP_RESET) && !idMode);

  assert_mfr_byte_R4: assert property (@(posedge clk) disable iff (!rstN)
    idMode && rdAddr == ADDR_W'(0) |-> rdData == MFR_ID);

endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrStrobe   (wrStrobe),
  .wrData     (wrData),
  .rdAddr     (rdAddr),
  .engineBusy (engineBusy),
  .reqAck     (reqAck),
  .reqValid   (reqValid),
  .reqOp      (reqOp),
  .reqAddr    (reqAddr),
  .reqData    (reqData),
  .idMode     (idMode),
  .rdData     (rdData),
  .progArmed  (progArmed)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrStrobe = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0]    arrayRdData = 8'h5A;
  logic          engineBusy = 1'b0;
  logic          reqAck = 1'b0;
  logic [7:0]    rdData, rdDataBot;
  logic          idMode, idModeBot;
  logic          reqValid, reqValidBot;
  logic [1:0]    reqOp, reqOpBot;
  logic [AW-1:0] reqAddr, reqAddrBot;
  logic [7:0]    reqData, reqDataBot;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .TOP_BOOT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .arrayRdData(arrayRdData), .rdData(rdData), .idMode(idMode),
    .engineBusy(engineBusy), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .reqAck(reqAck));

  flash_cmd_decoder #(.ADDR_W(AW), .TOP_BOOT(1'b0)) u_dut_bot (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .arrayRdData(arrayRdData), .rdData(rdDataBot), .idMode(idModeBot),
    .engineBusy(engineBusy), .reqValid(reqValidBot), .reqOp(reqOpBot), .reqAddr(reqAddrBot),
    .reqData(reqDataBot), .reqAck(reqAck));

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // ---------------- behavioural reference model ----------------
  typedef struct { logic [14:0] a; logic [7:0] d; } wr_t;
  wr_t           hist[$];
  logic          mValid = 1'b0;
  logic [1:0]    mOp = 2'd0;
  logic [AW-1:0] mAddr = '0;
  logic [7:0]    mData = '0;
  logic          mId = 1'b0;

  // -1 abort, 0 keep going, 1 program, 2 ident, 3 chip, 4 sector
  function automatic int classify();
    int  k = hist.size() - 1;
    wr_t w = hist[k];
    case (k)
      0: return (w.a == 15'h5555 && w.d == 8'hAA) ? 0 : -1;
      1: return (w.a == 15'h2AAA && w.d == 8'h55) ? 0 : -1;
      2: begin
        if (w.a != 15'h5555) return -1;
        if (w.d == 8'h90) return 2;
        if (w.d == 8'hA0 || w.d == 8'h80) return 0;
        return -1;
      end
      3: begin
        if (hist[2].d == 8'hA0) return 1;
        return (w.a == 15'h5555 && w.d == 8'hAA) ? 0 : -1;
      end
      4: return (w.a == 15'h2AAA && w.d == 8'h55) ? 0 : -1;
      5: begin
        if (w.a == 15'h5555 && w.d == 8'h10) return 3;
        if (w.d == 8'h30) return 4;
        return -1;
      end
      default: return -1;
    endcase
  endfunction

  task automatic modelIssue(input logic [1:0] op);
    mValid = 1'b1; mOp = op; mAddr = wrAddr; mData = wrData; mId = 1'b0;
    hist.delete();
  endtask

  task automatic modelAbort();
    mId = 1'b0;
    hist.delete();
  endtask

  task automatic modelEdge();
    logic pend;
    if (!rstN) begin
      mValid = 1'b0; mOp = 2'd0; mAddr = '0; mData = '0; mId = 1'b0; hist.delete();
      return;
    end
    pend = mValid;
    if (pend && reqAck) mValid = 1'b0;
    if (wrStrobe && !pend) begin
      logic inProgData;
      inProgData = (hist.size() == 3) && (hist[2].d == 8'hA0);
      if (wrData == 8'hF0 && (!inProgData || engineBusy)) modelIssue(2'd0);
      else if (engineBusy) modelAbort();
      else begin
        wr_t w;
        int  c;
        w.a = wrAddr[14:0]; w.d = wrData;
        hist.push_back(w);
        c = classify();
        case (c)
          -1: modelAbort();
          1: modelIssue(2'd1);
          2: begin mId = 1'b1; hist.delete(); end
          3: modelIssue(2'd2);
          4: modelIssue(2'd3);
          default: ;
        endcase
      end
    end
  endtask

  function automatic logic [7:0] modelRd(input logic [7:0] devByte);
    if (!mId) return arrayRdData;
    if (rdAddr == AW'(0)) return 8'h01;
    if (rdAddr == AW'(1)) return devByte;
    return 8'h00;
  endfunction

  task automatic compareAll();
    checks++;
    if (reqValid !== mValid) begin
      errors++; $display("FAIL R10 reqValid act=%0b exp=%0b @%0d", reqValid, mValid, cycles);
    end else if (mValid && (reqOp !== mOp || reqAddr !== mAddr || reqData !== mData)) begin
      errors++;
      $display("FAIL R10 payload act=%0d/%h/%h exp=%0d/%h/%h", reqOp, reqAddr, reqData, mOp, mAddr, mData);
    end
    if (idMode !== mId) begin
      errors++; $display("FAIL R4 idMode act=%0b exp=%0b @%0d", idMode, mId, cycles);
    end
    if (rdData !== modelRd(8'h40)) begin
      errors++; $display("FAIL R4 rdData act=%h exp=%h", rdData, modelRd(8'h40));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wrStrobe = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrStrobe = 1'b0;
  endtask

  task automatic keys(input logic [1:0] hi);
    wr({hi, 15'h5555}, 8'hAA);
    wr({hi, 15'h2AAA}, 8'h55);
  endtask

  task automatic ack();
    reqAck = 1'b1; tick(); reqAck = 1'b0;
  endtask

  task automatic expectReq(input string tag, input logic [1:0] op,
                           input logic [AW-1:0] a, input logic [7:0] d);
    checks++;
    if (reqValid !== 1'b1 || reqOp !== op || reqAddr !== a || reqData !== d) begin
      errors++;
      $display("FAIL %s req act=%0b/%0d/%h/%h exp=1/%0d/%h/%h", tag, reqValid, reqOp, reqAddr, reqData, op, a, d);
    end
  endtask

  task automatic expectNoReq(input string tag);
    checks++;
    if (reqValid !== 1'b0) begin
      errors++; $display("FAIL %s reqValid act=%0b exp=0", tag, reqValid);
    end
  endtask

  task automatic expectId(input string tag, input logic exp);
    checks++;
    if (idMode !== exp) begin
      errors++; $display("FAIL %s idMode act=%0b exp=%0b", tag, idMode, exp);
    end
  endtask

  task automatic expectRd(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s rdData act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=20000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // reset state
    expectNoReq("R10 reset");
    expectId("R4 reset", 1'b0);
    expectRd("R4 reset", rdData, 8'h5A);

    // R1: command without keys does nothing
    wr(17'h05555, 8'h90);
    expectId("R1 no keys", 1'b0);
    wr(17'h05555, 8'hA0);
    wr(17'h00100, 8'h12);
    expectNoReq("R1 no keys prog");

    // R4/R5: identifier mode, upper bits set on keys (R2)
    keys(2'b11);
    wr(17'h15555, 8'h90);
    expectId("R4 enter", 1'b1);
    expectNoReq("R4 no request");
    rdAddr = 17'h00000; tick();
    expectRd("R4 mfr", rdData, 8'h01);
    rdAddr = 17'h00001; tick();
    expectRd("R5 top dev", rdData, 8'h40);
    expectRd("R5 bottom dev", rdDataBot, 8'hA1);
    rdAddr = 17'h00005; tick();
    expectRd("R4 other addr", rdData, 8'h00);
    rdAddr = 17'h10001; tick();
    expectRd("R4 upper bits", rdData, 8'h00);

    // R3: one-write reset at arbitrary address
    wr(17'h1ABCD, 8'hF0);
    expectReq("R3 single", 2'd0, 17'h1ABCD, 8'hF0);
    expectId("R3 exits id", 1'b0);
    ack();
    expectNoReq("R10 ack clears");

    // R6 program with upper bits in key addresses (R2)
    keys(2'b10);
    wr(17'h15555, 8'hA0);
    wr(17'h1ABCD, 8'h3C);
    expectReq("R6 program", 2'd1, 17'h1ABCD, 8'h3C);
    expectReq("R2 upper bits", 2'd1, 17'h1ABCD, 8'h3C);
    // R10: hold without ack, writes ignored
    tick(); tick();
    expectReq("R10 held", 2'd1, 17'h1ABCD, 8'h3C);
    keys(2'b00);
    wr(17'h05555, 8'h90);
    expectId("R10 ignored while pending", 1'b0);
    expectReq("R10 payload stable", 2'd1, 17'h1ABCD, 8'h3C);
    ack();
    expectNoReq("R10 dropped");

    // R6 program data F0 is data, not reset
    keys(2'b00);
    wr(17'h05555, 8'hA0);
    wr(17'h00077, 8'hF0);
    expectReq("R6 F0 data", 2'd1, 17'h00077, 8'hF0);
    ack();

    // R3 keyed reset form
    keys(2'b00);
    wr(17'h05555, 8'hF0);
    expectReq("R3 keyed", 2'd0, 17'h05555, 8'hF0);
    ack();

    // R7 chip erase
    keys(2'b00);
    wr(17'h05555, 8'h80);
    keys(2'b01);
    wr(17'h05555, 8'h10);
    expectReq("R7 chip", 2'd2, 17'h05555, 8'h10);
    ack();

    // R8 sector erase
    keys(2'b00);
    wr(17'h05555, 8'h80);
    keys(2'b00);
    wr(17'h1C123, 8'h30);
    expectReq("R8 sector", 2'd3, 17'h1C123, 8'h30);
    ack();

    // R9 mismatch aborts, clears id mode, restarts
    keys(2'b00);
    wr(17'h05555, 8'h90);
    expectId("R9 setup", 1'b1);
    wr(17'h05555, 8'hAA);
    wr(17'h02AAB, 8'h55);
    expectId("R9 cleared", 1'b0);
    wr(17'h05555, 8'h90);
    expectId("R9 restart needed", 1'b0);
    keys(2'b00);
    wr(17'h05555, 8'h80);
    keys(2'b00);
    wr(17'h01234, 8'h10);
    expectNoReq("R9 chip at wrong addr");

    // R11 busy: only reset
    engineBusy = 1'b1;
    keys(2'b00);
    wr(17'h05555, 8'hA0);
    wr(17'h00010, 8'h99);
    expectNoReq("R11 program blocked");
    keys(2'b00);
    wr(17'h05555, 8'h80);
    keys(2'b00);
    wr(17'h05555, 8'h10);
    expectNoReq("R11 erase blocked");
    wr(17'h00042, 8'hF0);
    expectReq("R11 reset while busy", 2'd0, 17'h00042, 8'hF0);
    ack();
    // busy appears while programming is armed: F0 becomes reset
    engineBusy = 1'b0;
    keys(2'b00);
    wr(17'h05555, 8'hA0);
    engineBusy = 1'b1;
    wr(17'h00033, 8'hF0);
    expectReq("R11 armed F0 busy", 2'd0, 17'h00033, 8'hF0);
    ack();
    engineBusy = 1'b0;

    arrayRdData = 8'hC3;
    tick();
    expectRd("R4 array pass", rdData, 8'hC3);

    repeat (3) tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule